// File: doc/BRIEF.md
# Byte-Framed SPI Slave Front-End with Transfer Pause

This block is the serial edge of a memory device's command path. It runs directly on the SPI clock, with no system clock. It turns the bits arriving on the data input into whole bytes, most significant bit first, and marks the first byte of every chip-select window as the command byte. It also shifts reply bytes out on a data output that is tri-stated when not in use. The parallel side shows each received byte with a valid flag and a command flag. The same event raises a request for the next reply byte.

Clock modes 0 and 3 both work without a mode setting. Input bits are taken on rising clock edges and output bits change on falling edges. A falling edge that arrives before the first rising edge of a window does nothing, so the idle level of the clock at select time does not matter. Deselecting clears all framing state at once, without waiting for a clock edge. A pause input, honoured only while the device is selected, releases the output and freezes all framing. The transfer then resumes at the bit where it stopped.

Top module: `spi_slave_fe`

## Requirements
- R1: While `cs_n` is high, `so_oe`, `rx_valid`, `rx_cmd` and `tx_req` are low, and clock or data activity has no effect on the next transaction.
- R2: `si` is captured on each rising `sck` edge. Each group of 8 captured bits is one byte, first bit is the MSB. It is shown on `rx_byte` with `rx_valid` high from the eighth rising edge until the next rising edge.
- R3: `rx_cmd` is high together with `rx_valid` for the first byte after `cs_n` falls, and low for every later byte of that window.
- R4: `tx_req` rises at the same edge as `rx_valid`. `tx_byte` is loaded on the next falling `sck` edge and then appears on `so`, MSB first, one bit per falling edge. Each bit is stable before the rising edge on which the master samples it.
- R5: During the first byte of a window, `so` carries zeros. A falling `sck` edge before the first rising edge of the window does not shift the output.
- R6: Mode 0 (clock idle low) and mode 3 (clock idle high) give identical received bytes and output bits.
- R7: While `hold_n` is low with `cs_n` low, `so_oe` is low and `sck`/`si` edges change neither the bit position nor the shift registers. After `hold_n` returns high, shifting continues from the paused bit.
- R8: When `cs_n` rises before a byte is complete, the partial byte is dropped without any `rx_valid` pulse. The next window starts at bit 0 with a command byte.
- R9: Driving `hold_n` low while `cs_n` is high has no effect on the next transaction.
- R10: `so_oe` is high exactly when `cs_n` is low and `hold_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Chip select, active low; high clears framing asynchronously |
| sck | input | 1 | Serial clock, mode 0 or mode 3 |
| si | input | 1 | Serial data from master |
| hold_n | input | 1 | Pause, active low, honoured while selected |
| so | output | 1 | Serial data to master |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| tx_byte | input | DATA_W | Next reply byte, loaded after `tx_req` |
| tx_req | output | 1 | Request for the next reply byte |
| rx_byte | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | `rx_byte` is new, one SCK period wide |
| rx_cmd | output | 1 | Current `rx_byte` is the command byte |

## Verification
The embedded properties check these on every clock edge: the valid flag lines up with a wrapped bit position and lasts a single clock period. The command flag never appears without valid. A pause freezes the receive position and the transmit shift register. A leading falling edge leaves the output shift register cleared. The scenarios alone can show that byte values come through intact in both clock modes, that reply bytes show up in the next byte slot, and that a paused transfer resumes at the right bit. They also cover aborted partial bytes, which produce no valid pulse, and pause activity while deselected, which is ignored.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int FRAME_W = 8;

    // framing progress within one chip-select window
    typedef struct packed {
        logic started;     // a rising edge has been accepted
        logic first_done;  // the command byte has completed
    } rx_flags_t;

    // what the transmit path is told to do at a falling edge
    typedef enum logic [1:0] {
        TX_IDLE  = 2'b00,
        TX_SHIFT = 2'b01,
        TX_LOAD  = 2'b10
    } tx_op_e;

    function automatic int last_bit(input int width);
        return width - 1;
    endfunction

    function automatic tx_op_e pick_tx_op(input logic enable,
                                          input logic started,
                                          input logic boundary);
        if (!enable || !started) return TX_IDLE;
        if (boundary)            return TX_LOAD;
        return TX_SHIFT;
    endfunction

endpackage

// File: rtl/spi_fe_gate.sv
module spi_fe_gate (
    input  logic cs_n,
    input  logic hold_n,
    output logic shift_en,
    output logic so_oe
);
    // edges count only when not paused; output drives only while selected and not paused
    assign shift_en = hold_n;
    assign so_oe    = ~cs_n & hold_n;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = FRAME_W
) (
    input  logic              sck,
    input  logic              cs_n,
    input  logic              shift_en,
    input  logic              si,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_cmd,
    output logic              tx_req,
    output logic              started,
    output logic              boundary
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(last_bit(DATA_W));

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] sreg;
    rx_flags_t         flags;
    logic [DATA_W-1:0] next_sreg;
    logic              at_last;

    assign next_sreg = {sreg[DATA_W-2:0], si};
    assign at_last   = (bit_cnt == LAST);

    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            bit_cnt  <= '0;
            sreg     <= '0;
            flags    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_cmd   <= 1'b0;
            tx_req   <= 1'b0;
        end else if (shift_en) begin
            flags.started <= 1'b1;
            sreg          <= next_sreg;
            rx_valid      <= at_last;
            tx_req        <= at_last;
            rx_cmd        <= at_last & ~flags.first_done;
            if (at_last) begin
                bit_cnt          <= '0;
                rx_byte          <= next_sreg;
                flags.first_done <= 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign started  = flags.started;
    assign boundary = flags.started & (bit_cnt == '0);

    // R2
    valid_align_chk: assert property (@(posedge sck) disable iff (cs_n)
        rx_valid |-> (bit_cnt == '0));

    // R2
    valid_pulse_chk: assert property (@(posedge sck) disable iff (cs_n)
        (rx_valid && shift_en) |=> !rx_valid);

    // R3
    cmd_with_valid_chk: assert property (@(posedge sck) disable iff (cs_n)
        rx_cmd |-> rx_valid);

    // R7
    hold_freeze_chk: assert property (@(posedge sck) disable iff (cs_n)
        !shift_en |=> ($stable(bit_cnt) && $stable(sreg)));

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = FRAME_W
) (
    input  logic              sck,
    input  logic              cs_n,
    input  logic              shift_en,
    input  logic              started,
    input  logic              boundary,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              so
);
    logic [DATA_W-1:0] tsreg;
    tx_op_e            op;

    assign op = pick_tx_op(shift_en, started, boundary);

    always_ff @(negedge sck or posedge cs_n) begin
        if (cs_n) begin
            tsreg <= '0;
        end else begin
            case (op)
                TX_LOAD:  tsreg <= tx_byte;
                TX_SHIFT: tsreg <= {tsreg[DATA_W-2:0], 1'b0};
                default:  tsreg <= tsreg;
            endcase
        end
    end

    assign so = tsreg[DATA_W-1];

    // R5
    lead_fall_chk: assert property (@(negedge sck) disable iff (cs_n)
        !started |=> (tsreg == '0));

    // R7
    tx_hold_chk: assert property (@(negedge sck) disable iff (cs_n)
        !shift_en |=> $stable(tsreg));

endmodule

// File: rtl/spi_slave_fe.sv
module spi_slave_fe
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = FRAME_W
) (
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_req,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_cmd
);
    logic shift_en;
    logic started;
    logic boundary;

    spi_fe_gate u_gate (
        .cs_n     (cs_n),
        .hold_n   (hold_n),
        .shift_en (shift_en),
        .so_oe    (so_oe)
    );

    spi_fe_rx #(.DATA_W(DATA_W)) u_rx (
        .sck      (sck),
        .cs_n     (cs_n),
        .shift_en (shift_en),
        .si       (si),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_cmd   (rx_cmd),
        .tx_req   (tx_req),
        .started  (started),
        .boundary (boundary)
    );

    spi_fe_tx #(.DATA_W(DATA_W)) u_tx (
        .sck      (sck),
        .cs_n     (cs_n),
        .shift_en (shift_en),
        .started  (started),
        .boundary (boundary),
        .tx_byte  (tx_byte),
        .so       (so)
    );

    // R4
    req_with_valid_chk: assert property (@(posedge sck) disable iff (cs_n)
        tx_req |-> rx_valid);

endmodule

// File: tb/sim_spi_slave_fe.sv
module sim_spi_slave_fe;

    logic       clk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       so, so_oe, tx_req, rx_valid, rx_cmd;
    logic [7:0] rx_byte;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    logic [8:0] exp_q[$];   // {cmd, data}
    bit         is_first;
    bit         have_prev;
    logic [7:0] prev_tx;
    int         mode;

    always #2.5 clk = ~clk;

    spi_slave_fe u0 (
        .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .tx_byte(tx_byte), .tx_req(tx_req),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_cmd(rx_cmd)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // scoreboard monitor
    always @(posedge sck) begin
        #1;
        if (rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected rx_valid", {23'd0, rx_cmd, rx_byte}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(rx_byte == e[7:0], "R2 rx_byte", rx_byte, e[7:0]);
                chk(rx_cmd == e[8], "R3 rx_cmd", rx_cmd, e[8]);
                chk(tx_req == 1'b1, "R4 tx_req", tx_req, 1);
            end
        end
    end

    task automatic begin_txn(input int m);
        mode = m;
        sck = (m == 3);
        wclk(2);
        cs_n = 1'b0;
        wclk(2);
        is_first = 1;
        have_prev = 0;
    endtask

    task automatic end_txn();
        wclk(2);
        cs_n = 1'b1;
        wclk(2);
        sck = (mode == 3);
        wclk(2);
    endtask

    task automatic do_hold();
        hold_n = 1'b0;
        wclk(1);
        chk(so_oe == 1'b0, "R7 so_oe during hold", so_oe, 0);
        chk(so_oe == 1'b0, "R10 oe off in pause", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
            si = k[0];
            sck = 1'b1; wclk(2);
            sck = 1'b0; wclk(2);
        end
        hold_n = 1'b1;
        wclk(2);
    endtask

    task automatic xfer(input logic [7:0] mosi, input logic [7:0] miso_next, input int hold_at);
        logic [7:0] exp_so;
        exp_so = have_prev ? prev_tx : 8'h00;
        exp_q.push_back({is_first, mosi});
        for (int i = 0; i < 8; i++) begin
            if (sck) begin sck = 1'b0; wclk(2); end
            if (i == 1) tx_byte = miso_next;
            if (i == hold_at) do_hold();
            si = mosi[7-i];
            wclk(2);
            if (have_prev) chk(so == exp_so[7-i], $sformatf("R4 so bit %0d R6 mode %0d", i, mode), so, exp_so[7-i]);
            else           chk(so == 1'b0, $sformatf("R5 first-byte so bit %0d mode %0d", i, mode), so, 0);
            chk(so_oe == 1'b1, "R10 so_oe selected", so_oe, 1);
            sck = 1'b1;
            wclk(2);
        end
        if (mode == 0) begin sck = 1'b0; wclk(2); end
        prev_tx = miso_next;
        have_prev = 1;
        is_first = 0;
    endtask

    initial begin
        wclk(4);
        // R1: idle state and activity while deselected
        chk(so_oe == 0, "R1 so_oe idle", so_oe, 0);
        chk(rx_valid == 0, "R1 rx_valid idle", rx_valid, 0);
        chk(tx_req == 0, "R1 tx_req idle", tx_req, 0);
        for (int k = 0; k < 5; k++) begin
            si = 1'b1; sck = 1'b1; wclk(2); sck = 1'b0; wclk(2);
        end
        chk(rx_valid == 0 && so_oe == 0, "R1 deselected activity", {rx_valid, so_oe}, 0);

        // mode 0 multi-byte
        begin_txn(0);
        xfer(8'hA5, 8'h3C, -1);
        xfer(8'h5A, 8'hF0, -1);
        xfer(8'h81, 8'h0F, -1);
        xfer(8'h00, 8'hAA, -1);
        end_txn();
        chk(so_oe == 0 && rx_valid == 0, "R1 after deselect", {so_oe, rx_valid}, 0);

        // mode 3 multi-byte (R6), leading falling edge (R5)
        begin_txn(3);
        xfer(8'hC3, 8'h96, -1);
        xfer(8'h7E, 8'h12, -1);
        xfer(8'hFF, 8'h69, -1);
        end_txn();

        // R7: pause mid-byte in both modes
        begin_txn(0);
        xfer(8'h9B, 8'hB4, 3);
        xfer(8'h24, 8'h5D, 5);
        xfer(8'hE1, 8'h00, -1);
        end_txn();
        begin_txn(3);
        xfer(8'h4D, 8'hC7, 2);
        xfer(8'hB2, 8'h31, 6);
        end_txn();

        // R8: partial byte then a new window
        begin_txn(0);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; wclk(2); sck = 1'b1; wclk(2); sck = 1'b0;
        end
        wclk(1);
        chk(rx_valid == 0, "R8 no valid on partial", rx_valid, 0);
        end_txn();
        chk(rx_valid == 0, "R8 no valid after abort", rx_valid, 0);
        begin_txn(0);
        xfer(8'h17, 8'h88, -1);
        xfer(8'h6C, 8'h00, -1);
        end_txn();

        // R9: pause while deselected
        hold_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            si = 1'b1; sck = 1'b1; wclk(2); sck = 1'b0; wclk(2);
        end
        chk(so_oe == 0, "R9 so_oe while deselected", so_oe, 0);
        hold_n = 1'b1;
        wclk(2);
        begin_txn(3);
        xfer(8'h3A, 8'hD2, -1);
        xfer(8'hC5, 8'h00, -1);
        end_txn();

        wclk(4);
        chk(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule